// File: doc/BRIEF.md
# Multi-Mode Register Shift Unit

This block performs the shift operations of a 16-bit word machine. When a shift is started it takes a copy of three working registers (T, D and A) and of the link bit. It then shifts one register, or the A and D registers joined into one 32-bit operand, by up to 32 positions. The instruction fields choose the register, the kind of shift, the direction and the shift count.

The shift takes one bit position per clock cycle. The bit that fills the vacated end depends on the kind of shift: zero, a copy of the sign bit, the bit leaving the other end, or the current link bit. After every position, the bit that leaves the operand becomes the new link bit. A single-cycle `done` pulse marks the result as final. The surrounding core writes the three register outputs and the link output back into its register file on that pulse. The outputs keep their values until the next shift is accepted.

Top module: `regshift_unit`

## Requirements
- R1: `tgt_sel` picks the operand: 0 = T, 1 = D, 2 = A, 3 = the A:D pair, with A as bits 31..16 and D as bits 15..0. Registers outside the chosen operand come out equal to the values captured at start.
- R2: With `kind_sel` = 0 (arithmetic), a left shift fills bit 0 with zero. A right shift copies the operand's top bit (bit 15, or bit 31 for the pair) into itself.
- R3: With `kind_sel` = 1 (rotate), the bit that leaves one end enters the other end.
- R4: With `kind_sel` = 2 (zero fill), the vacated end receives zero in both directions.
- R5: With `kind_sel` = 3 (link fill), the vacated end receives the current link bit. Because the link is updated after every position, a 16-bit operand with count 17 returns both the operand and the link to their start values.
- R6: `dir_right` = 0 shifts toward the most significant bit; `dir_right` = 1 shifts toward the least significant bit.
- R7: After every position, in every kind of shift, `link_out` holds the bit that was just shifted out.
- R8: A count of 0 returns the captured registers and link unchanged. `done` is asserted in the cycle after start.
- R9: A count above 32 is treated as 32.
- R10: The block shifts one position per clock. `done` is high for exactly one cycle, N+1 cycles after the start cycle, where N is the count after limiting to 32.
- R11: A `start` that arrives while a shift is in progress is ignored.
- R12: Reset clears all outputs to zero with `done` low. After `done`, the outputs hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a shift; register and link inputs are captured |
| tgt_sel | input | 2 | Operand select (R1 encoding) |
| kind_sel | input | 2 | Shift kind (R2 to R5 encoding) |
| dir_right | input | 1 | 1 = shift right |
| count | input | 6 | Shift count, values above 32 limited to 32 |
| t_in | input | 16 | T register value |
| d_in | input | 16 | D register value |
| a_in | input | 16 | A register value |
| link_in | input | 1 | Link bit value |
| t_out | output | 16 | Shifted T |
| d_out | output | 16 | Shifted D |
| a_out | output | 16 | Shifted A |
| link_out | output | 1 | New link bit |
| done | output | 1 | One-cycle pulse, result final |

## Verification
The bench aims at the following corner cases and the failure each one exposes:
- **Bits crossing between A and D on the pair.** A unit that shifted the two halves separately would lose the bits that cross, or keep the wrong sign.
- **Rotation by exactly 16 and by 32.** These show whether the link receives the right bit when the operand comes back to its starting value.
- **A 17-position link-fill shift.** It passes only if the link is fed back after every position.
- **Counts of 0 and 40.** A unit without the count limit would rotate 8 extra positions. A zero-count path that shifted once would corrupt the operand.
- **A second start during a shift.** A unit that accepted it would end with the wrong register changed and a shortened latency.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

    typedef enum logic [1:0] {
        TGT_T  = 2'd0,
        TGT_D  = 2'd1,
        TGT_A  = 2'd2,
        TGT_AD = 2'd3
    } shift_tgt_e;

    typedef enum logic [1:0] {
        KIND_ARITH = 2'd0,
        KIND_ROT   = 2'd1,
        KIND_ZERO  = 2'd2,
        KIND_LINK  = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/rsu_step.sv
// One bit position of shifting on a W-bit operand, purely combinational.
module rsu_step
    import rsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] op,
    input  shift_kind_e  kind,
    input  logic         right,
    input  logic         link,
    output logic [W-1:0] res,
    output logic         out_bit
);
    logic fill;

    always_comb begin
        fill = 1'b0;
        if (right) begin
            out_bit = op[0];
            case (kind)
                KIND_ARITH: fill = op[W-1];
                KIND_ROT:   fill = op[0];
                KIND_ZERO:  fill = 1'b0;
                KIND_LINK:  fill = link;
                default:    fill = 1'b0;
            endcase
            res = {fill, op[W-1:1]};
        end else begin
            out_bit = op[W-1];
            case (kind)
                KIND_ARITH: fill = 1'b0;
                KIND_ROT:   fill = op[W-1];
                KIND_ZERO:  fill = 1'b0;
                KIND_LINK:  fill = link;
                default:    fill = 1'b0;
            endcase
            res = {op[W-2:0], fill};
        end
    end
endmodule

// File: rtl/rsu_seq.sv
// Position counter: accepts a start, limits the count, pulses done.
module rsu_seq #(
    parameter int MAX_SHIFT = 32,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             load,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_SHIFT);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] rem;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] cnt_lim;

    assign cnt_lim = (count > MAX_C) ? MAX_C : count;
    assign load    = start && !s_q.busy;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.rem = s_q.rem - 1'b1;
            if (s_q.rem == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (load) begin
            if (cnt_lim == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.rem  = cnt_lim;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
endmodule

// File: rtl/regshift_unit.sv
module regshift_unit
    import rsu_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int MAX_SHIFT = 2 * WORD_W,
    parameter int CNT_W     = $clog2(MAX_SHIFT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        tgt_sel,
    input  logic [1:0]        kind_sel,
    input  logic              dir_right,
    input  logic [CNT_W-1:0]  count,
    input  logic [WORD_W-1:0] t_in,
    input  logic [WORD_W-1:0] d_in,
    input  logic [WORD_W-1:0] a_in,
    input  logic              link_in,
    output logic [WORD_W-1:0] t_out,
    output logic [WORD_W-1:0] d_out,
    output logic [WORD_W-1:0] a_out,
    output logic              link_out,
    output logic              done
);
    localparam int PAIR_W = 2 * WORD_W;

    typedef struct packed {
        shift_tgt_e        tgt;
        shift_kind_e       kind;
        logic              right;
        logic [WORD_W-1:0] t;
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] a;
        logic              link;
    } dp_t;

    dp_t st_d, st_q;
    logic seq_load, seq_busy;

    logic [WORD_W-1:0] w_op, w_res;
    logic [PAIR_W-1:0] p_res;
    logic              w_out, p_out;

    rsu_seq #(.MAX_SHIFT(MAX_SHIFT), .CNT_W(CNT_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .count (count),
        .load  (seq_load),
        .busy  (seq_busy),
        .done  (done)
    );

    always_comb begin
        case (st_q.tgt)
            TGT_T:   w_op = st_q.t;
            TGT_D:   w_op = st_q.d;
            default: w_op = st_q.a;
        endcase
    end

    rsu_step #(.W(WORD_W)) u_word (
        .op(w_op), .kind(st_q.kind), .right(st_q.right), .link(st_q.link),
        .res(w_res), .out_bit(w_out)
    );

    rsu_step #(.W(PAIR_W)) u_pair (
        .op({st_q.a, st_q.d}), .kind(st_q.kind), .right(st_q.right), .link(st_q.link),
        .res(p_res), .out_bit(p_out)
    );

    always_comb begin
        st_d = st_q;
        if (seq_load) begin
            st_d.tgt   = shift_tgt_e'(tgt_sel);
            st_d.kind  = shift_kind_e'(kind_sel);
            st_d.right = dir_right;
            st_d.t     = t_in;
            st_d.d     = d_in;
            st_d.a     = a_in;
            st_d.link  = link_in;
        end else if (seq_busy) begin
            case (st_q.tgt)
                TGT_T: begin
                    st_d.t    = w_res;
                    st_d.link = w_out;
                end
                TGT_D: begin
                    st_d.d    = w_res;
                    st_d.link = w_out;
                end
                TGT_A: begin
                    st_d.a    = w_res;
                    st_d.link = w_out;
                end
                default: begin
                    st_d.a    = p_res[PAIR_W-1:WORD_W];
                    st_d.d    = p_res[WORD_W-1:0];
                    st_d.link = p_out;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign t_out    = st_q.t;
    assign d_out    = st_q.d;
    assign a_out    = st_q.a;
    assign link_out = st_q.link;
endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  count,
    input logic [WORD_W-1:0] t_in,
    input logic              link_in,
    input logic [WORD_W-1:0] t_out,
    input logic [WORD_W-1:0] d_out,
    input logic [WORD_W-1:0] a_out,
    input logic              link_out,
    input logic              done,
    input logic              busy,
    input logic [1:0]        cur_tgt,
    input logic [1:0]        cur_kind,
    input logic              cur_right
);
    // R10: done lasts one cycle unless a new zero-count shift follows
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);

    // R10: done never overlaps an ongoing shift
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: zero count returns captured values next cycle
    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && count == '0 |=>
            done && t_out == $past(t_in) && link_out == $past(link_in));

    // R12: idle outputs hold
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(t_out) && $stable(d_out) && $stable(a_out) && $stable(link_out));

    // R11: captured controls do not change during a shift
    a_r11_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_tgt) && $stable(cur_kind) && $stable(cur_right));

    // R1: shifting T leaves D and A alone
    a_r1_t_only: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cur_tgt == 2'd0 |=> $stable(d_out) && $stable(a_out));

    // R3: rotating T keeps the count of ones
    a_r3_rot_ones: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cur_tgt == 2'd0 && cur_kind == 2'd1 |=> $countones(t_out) == $countones($past(t_out)));

    // R4: zero fill left on T leaves bit 0 clear
    a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cur_tgt == 2'd0 && cur_kind == 2'd2 && !cur_right |=> t_out[0] == 1'b0);

    // R5: link fill right on the pair puts the old link into A's top bit
    a_r5_link_pair: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cur_tgt == 2'd3 && cur_kind == 2'd3 && cur_right |=> a_out[WORD_W-1] == $past(link_out));
endmodule

bind regshift_unit rsu_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count), .t_in(t_in),
    .link_in(link_in), .t_out(t_out), .d_out(d_out), .a_out(a_out),
    .link_out(link_out), .done(done), .busy(seq_busy),
    .cur_tgt(st_q.tgt), .cur_kind(st_q.kind), .cur_right(st_q.right)
);

// File: tb/regshift_unit_tb.sv
module regshift_unit_tb;

    typedef struct packed {
        logic [1:0]  tgt;
        logic [1:0]  kind;
        logic        right;
        logic [5:0]  cnt;
        logic [15:0] t;
        logic [15:0] d;
        logic [15:0] a;
        logic        link;
        logic [15:0] et;
        logic [15:0] ed;
        logic [15:0] ea;
        logic        el;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 1'b0, 6'd4,  16'h1234, 16'hAAAA, 16'h5555, 1'b0, 16'h2340, 16'hAAAA, 16'h5555, 1'b1},
        '{2'd1, 2'd0, 1'b1, 6'd3,  16'h1111, 16'h8005, 16'h2222, 1'b0, 16'h1111, 16'hF000, 16'h2222, 1'b1},
        '{2'd2, 2'd1, 1'b0, 6'd8,  16'h3333, 16'h4444, 16'h12F0, 1'b1, 16'h3333, 16'h4444, 16'hF012, 1'b0},
        '{2'd2, 2'd2, 1'b1, 6'd16, 16'h0F0F, 16'h7777, 16'hFFFF, 1'b0, 16'h0F0F, 16'h7777, 16'h0000, 1'b1},
        '{2'd0, 2'd3, 1'b0, 6'd1,  16'h0001, 16'h6666, 16'h9999, 1'b1, 16'h0003, 16'h6666, 16'h9999, 1'b0},
        '{2'd3, 2'd0, 1'b0, 6'd4,  16'hC3C3, 16'hF000, 16'h0001, 1'b1, 16'hC3C3, 16'h0000, 16'h001F, 1'b0},
        '{2'd3, 2'd0, 1'b1, 6'd8,  16'h0000, 16'h00FF, 16'h8000, 1'b0, 16'h0000, 16'h0000, 16'hFF80, 1'b1},
        '{2'd3, 2'd1, 1'b1, 6'd16, 16'h5A5A, 16'hABCD, 16'h1234, 1'b0, 16'h5A5A, 16'h1234, 16'hABCD, 1'b1},
        '{2'd0, 2'd1, 1'b1, 6'd32, 16'hBEEF, 16'h0101, 16'h0202, 1'b0, 16'hBEEF, 16'h0101, 16'h0202, 1'b1},
        '{2'd1, 2'd0, 1'b0, 6'd0,  16'h0F0F, 16'h1357, 16'h2468, 1'b1, 16'h0F0F, 16'h1357, 16'h2468, 1'b1},
        '{2'd3, 2'd3, 1'b1, 6'd1,  16'h0000, 16'h0001, 16'h0000, 1'b1, 16'h0000, 16'h0000, 16'h8000, 1'b1},
        '{2'd3, 2'd2, 1'b0, 6'd32, 16'h1111, 16'h0001, 16'hFFFF, 1'b0, 16'h1111, 16'h0000, 16'h0000, 1'b1},
        '{2'd2, 2'd3, 1'b1, 6'd17, 16'h0000, 16'h0000, 16'h5A3C, 1'b1, 16'h0000, 16'h0000, 16'h5A3C, 1'b1},
        '{2'd0, 2'd1, 1'b0, 6'd40, 16'h00FF, 16'h0000, 16'h0000, 1'b0, 16'h00FF, 16'h0000, 16'h0000, 1'b1},
        '{2'd1, 2'd3, 1'b0, 6'd2,  16'h0000, 16'h8000, 16'h0000, 1'b1, 16'h0000, 16'h0003, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  tgt_sel = '0;
    logic [1:0]  kind_sel = '0;
    logic        dir_right = 1'b0;
    logic [5:0]  count = '0;
    logic [15:0] t_in = '0, d_in = '0, a_in = '0;
    logic        link_in = 1'b0;
    logic [15:0] t_out, d_out, a_out;
    logic        link_out, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    regshift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_sel(tgt_sel),
        .kind_sel(kind_sel), .dir_right(dir_right), .count(count),
        .t_in(t_in), .d_in(d_in), .a_in(a_in), .link_in(link_in),
        .t_out(t_out), .d_out(d_out), .a_out(a_out),
        .link_out(link_out), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    // Pulse start at a negedge, return cycles until done is seen.
    task automatic launch(input logic [1:0] tg, input logic [1:0] kd, input logic rt,
                          input logic [5:0] c, input logic [15:0] t, input logic [15:0] d,
                          input logic [15:0] a, input logic lk, output int lat);
        tgt_sel = tg; kind_sel = kd; dir_right = rt; count = c;
        t_in = t; d_in = d; a_in = a; link_in = lk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t_in = ~t; d_in = ~d; a_in = ~a; link_in = ~lk;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int lat;
        int exp_lat;
        @(negedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12 reset outputs", {t_out, d_out, a_out, link_out, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].tgt, VECS[i].kind, VECS[i].right, VECS[i].cnt,
                   VECS[i].t, VECS[i].d, VECS[i].a, VECS[i].link, lat);
            exp_lat = ((VECS[i].cnt > 6'd32) ? 32 : int'(VECS[i].cnt)) + 1;
            check($sformatf("R1 R6 %s vec %0d regs", kind_tag(VECS[i].kind), i),
                  {t_out, d_out, a_out}, {VECS[i].et, VECS[i].ed, VECS[i].ea});
            check($sformatf("R7 vec %0d link", i), link_out, VECS[i].el);
            check($sformatf("R10 vec %0d latency", i), lat, exp_lat);
            if (VECS[i].cnt == 6'd0)
                check($sformatf("R8 vec %0d zero count unchanged", i), {d_out, link_out}, {VECS[i].d, VECS[i].link});
            if (VECS[i].cnt > 6'd32)
                check($sformatf("R9 vec %0d limited count", i), t_out, VECS[i].t);
            @(negedge clk);
            check($sformatf("R10 vec %0d done single cycle", i), done, 1'b0);
        end

        // R12: outputs hold after done while inputs wander
        launch(2'd3, 2'd0, 1'b0, 6'd4, 16'hC3C3, 16'hF000, 16'h0001, 1'b1, lat);
        repeat (3) @(negedge clk);
        check("R12 hold after done", {t_out, d_out, a_out, link_out}, {16'hC3C3, 16'h0000, 16'h001F, 1'b0});

        // R11: second start during a shift is ignored
        tgt_sel = 2'd0; kind_sel = 2'd1; dir_right = 1'b0; count = 6'd20;
        t_in = 16'h0001; d_in = 16'h0BAD; a_in = 16'h0CAB; link_in = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        @(negedge clk); lat++;
        @(negedge clk); lat++;
        tgt_sel = 2'd1; count = 6'd1; d_in = 16'hFFFF; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R11 ignored start regs", {t_out, d_out, a_out}, {16'h0010, 16'h0BAD, 16'h0CAB});
        check("R11 ignored start link", link_out, 1'b0);
        check("R11 ignored start latency", lat, 21);

        // R12: reset mid-result clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset after use", {t_out, d_out, a_out, link_out, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        report();
    end
endmodule